// File: doc/BRIEF.md
# Watchpoint to Breakpoint Generator

This block sits beside a processor core's debug logic. It takes a set of watchpoint match signals and copies them onto dedicated output pins. These pins only report. They never stall or redirect execution. The same matches can also become a breakpoint request, which sends the core to its debug exception handler. A match does this only when its trap enable bit is set and its occurrence counter has run out.

Each watchpoint has a programmable occurrence count. A count of zero or one breaks on the first enabled match. A larger count N breaks on the Nth enabled match, and the counter then reloads so that the next break again needs N matches. Two masters can write the trap enable bits: a software register port and a debug serial port. If both write in the same cycle, the serial port's value is taken. External breakpoint requests also raise the request; these come from peripherals through the serial debug port. The request stays high until the core acknowledges it, and any events that arrive meanwhile are merged into it.

Top module: `wpb_gen`

## Requirements
- R1: `wp_pin_o` equals the value `wp_match_i` had one cycle earlier, for every bit, whatever the trap enable state.
- R2: After reset, `brk_req_o` and `wp_pin_o` are 0, all trap enables are cleared, and every occurrence count is 0.
- R3: With a loaded count of 0 or 1, the first cycle in which an enabled watchpoint matches makes `brk_req_o` high in the following cycle.
- R4: A watchpoint whose trap enable bit is 0 never raises `brk_req_o`, and its matches are not counted.
- R5: `sw_te_we` and `ser_te_we` each load the full trap enable vector (bit i enables watchpoint i). When both are high in one cycle, `ser_te_data` is stored.
- R6: `ext_brk_i` high in a cycle makes `brk_req_o` high in the next cycle.
- R7: With a loaded count N > 1, `brk_req_o` rises only after the Nth cycle in which that enabled watchpoint matches. Each cycle with the match high counts as one occurrence.
- R8: After a counter raises a breakpoint, it reloads its programmed value, and the next breakpoint needs N further occurrences.
- R9: `brk_req_o` stays high until `brk_ack_i` is seen. It is 0 in the cycle after the acknowledge unless a new event arrived in the acknowledge cycle, in which case it stays 1.
- R10: A count write (`cnt_we` bit i) in the same cycle as a match on watchpoint i takes precedence. That match is neither counted nor able to break.
- R11: Each watchpoint has its own counter and reload value, so occurrences on one watchpoint do not affect the count of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_match_i | input | NUM_WP | Watchpoint match conditions, one bit per watchpoint |
| wp_pin_o | output | NUM_WP | Watchpoint report pins |
| sw_te_we | input | 1 | Software write strobe for the trap enable vector |
| sw_te_data | input | NUM_WP | Software trap enable value |
| ser_te_we | input | 1 | Serial debug port write strobe for the trap enable vector |
| ser_te_data | input | NUM_WP | Serial debug port trap enable value |
| cnt_we | input | NUM_WP | Per-watchpoint count load strobes |
| cnt_data | input | CNT_W | Occurrence count loaded by `cnt_we` |
| ext_brk_i | input | 1 | External breakpoint request from the serial debug port |
| brk_ack_i | input | 1 | Core acknowledge that clears the breakpoint request |
| brk_req_o | output | 1 | Breakpoint request to the core |

## Verification
The assertions assume that `brk_ack_i` is only meaningful while a request is pending. They also assume that every watchpoint match and external request is a level sampled once per clock, so a match held for k cycles counts as k occurrences. The bench drives all inputs one time unit after the rising edge and returns them to idle between scenarios. It only raises the acknowledge when `brk_req_o` is high. When it wants to see a request cleared, it keeps `ext_brk_i` and the enabled matches low in the acknowledge cycle.

// File: rtl/wpb_pkg.sv
package wpb_pkg;
   // Source chosen for the trap enable register in a given cycle
   typedef enum logic [1:0] {
      TE_HOLD = 2'd0,
      TE_SW   = 2'd1,
      TE_SER  = 2'd2
   } te_src_e;
endpackage

// File: rtl/wpb_te_arb.sv
module wpb_te_arb #(
   parameter int NUM_WP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [NUM_WP-1:0] sw_data,
   input  logic              ser_we,
   input  logic [NUM_WP-1:0] ser_data,
   output logic [NUM_WP-1:0] te_q
);
   import wpb_pkg::*;

   te_src_e src;

   // Serial port outranks software on a same-cycle collision
   always_comb begin
      if (ser_we)     src = TE_SER;
      else if (sw_we) src = TE_SW;
      else            src = TE_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         te_q <= '0;
      end else begin
         case (src)
            TE_SER:  te_q <= ser_data;
            TE_SW:   te_q <= sw_data;
            default: te_q <= te_q;
         endcase
      end
   end
endmodule

// File: rtl/wpb_occ_cnt.sv
module wpb_occ_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W-1:0] ld_val,
   input  logic             hit,
   output logic             fire
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rld_q;
   logic             last;

   assign last = (cnt_q <= ONE);
   // A load in the same cycle hides the occurrence
   assign fire = hit & ~ld & last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         rld_q <= '0;
      end else if (ld) begin
         cnt_q <= ld_val;
         rld_q <= ld_val;
      end else if (hit) begin
         cnt_q <= last ? rld_q : (cnt_q - ONE);
      end
   end
endmodule

// File: rtl/wpb_brk_hold.sv
module wpb_brk_hold (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic req_q
);
   // New events win over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   req_q <= 1'b0;
      else if (set) req_q <= 1'b1;
      else if (ack) req_q <= 1'b0;
   end
endmodule

// File: rtl/wpb_gen.sv
module wpb_gen #(
   parameter int NUM_WP  = 4,
   parameter int CNT_W   = 8,
   parameter bit PIN_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_WP-1:0] wp_match_i,
   output logic [NUM_WP-1:0] wp_pin_o,
   input  logic              sw_te_we,
   input  logic [NUM_WP-1:0] sw_te_data,
   input  logic              ser_te_we,
   input  logic [NUM_WP-1:0] ser_te_data,
   input  logic [NUM_WP-1:0] cnt_we,
   input  logic [CNT_W-1:0]  cnt_data,
   input  logic              ext_brk_i,
   input  logic              brk_ack_i,
   output logic              brk_req_o
);
   localparam int MAX_WP = 32;

   if (NUM_WP < 1 || NUM_WP > MAX_WP) begin : g_bad_num
      $error("wpb_gen: NUM_WP out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("wpb_gen: CNT_W must be at least 1");
   end

   logic [NUM_WP-1:0] te_q;
   logic [NUM_WP-1:0] hit;
   logic [NUM_WP-1:0] fire;
   logic              brk_set;

   wpb_te_arb #(.NUM_WP(NUM_WP)) u_te (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_we    (sw_te_we),
      .sw_data  (sw_te_data),
      .ser_we   (ser_te_we),
      .ser_data (ser_te_data),
      .te_q     (te_q)
   );

   assign hit = wp_match_i & te_q;

   for (genvar i = 0; i < NUM_WP; i++) begin : g_wp
      wpb_occ_cnt #(.CNT_W(CNT_W)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld     (cnt_we[i]),
         .ld_val (cnt_data),
         .hit    (hit[i]),
         .fire   (fire[i])
      );
   end

   assign brk_set = (|fire) | ext_brk_i;

   wpb_brk_hold u_brk (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (brk_set),
      .ack   (brk_ack_i),
      .req_q (brk_req_o)
   );

   if (PIN_REG) begin : g_pin_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wp_pin_o <= '0;
         else        wp_pin_o <= wp_match_i;
      end
   end else begin : g_pin_comb
      assign wp_pin_o = wp_match_i;
   end
endmodule

// File: rtl/wpb_gen_chk.sv
module wpb_gen_chk #(
   parameter int NUM_WP  = 4,
   parameter bit PIN_REG = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_WP-1:0] wp_match_i,
   input logic [NUM_WP-1:0] wp_pin_o,
   input logic              ser_te_we,
   input logic [NUM_WP-1:0] ser_te_data,
   input logic              ext_brk_i,
   input logic              brk_ack_i,
   input logic              brk_req_o,
   input logic [NUM_WP-1:0] te_q
);
   if (PIN_REG) begin : g_pin_chk
      AST_PIN_DELAYED: assert property (@(posedge clk) disable iff (!rst_n)
         ##1 wp_pin_o == $past(wp_match_i)); // R1
   end

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!brk_req_o && !ext_brk_i && ((wp_match_i & te_q) == '0)) |=> !brk_req_o); // R4

   AST_SER_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      ser_te_we |=> (te_q == $past(ser_te_data))); // R5

   AST_EXT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      ext_brk_i |=> brk_req_o); // R6

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req_o && !brk_ack_i) |=> brk_req_o); // R9

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req_o && brk_ack_i && !ext_brk_i && ((wp_match_i & te_q) == '0))
      |=> !brk_req_o); // R9
endmodule

bind wpb_gen wpb_gen_chk #(.NUM_WP(NUM_WP), .PIN_REG(PIN_REG)) u_wpb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wp_match_i  (wp_match_i),
   .wp_pin_o    (wp_pin_o),
   .ser_te_we   (ser_te_we),
   .ser_te_data (ser_te_data),
   .ext_brk_i   (ext_brk_i),
   .brk_ack_i   (brk_ack_i),
   .brk_req_o   (brk_req_o),
   .te_q        (te_q)
);

// File: tb/tb_wpb_gen.sv
`timescale 1ns/1ps
module tb_wpb_gen;
   localparam int NUM_WP = 4;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_WP-1:0] wp_match_i = '0;
   logic [NUM_WP-1:0] wp_pin_o;
   logic              sw_te_we = 1'b0;
   logic [NUM_WP-1:0] sw_te_data = '0;
   logic              ser_te_we = 1'b0;
   logic [NUM_WP-1:0] ser_te_data = '0;
   logic [NUM_WP-1:0] cnt_we = '0;
   logic [CNT_W-1:0]  cnt_data = '0;
   logic              ext_brk_i = 1'b0;
   logic              brk_ack_i = 1'b0;
   logic              brk_req_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wpb_gen #(.NUM_WP(NUM_WP), .CNT_W(CNT_W)) dut (
      .clk(clk), .rst_n(rst_n), .wp_match_i(wp_match_i), .wp_pin_o(wp_pin_o),
      .sw_te_we(sw_te_we), .sw_te_data(sw_te_data),
      .ser_te_we(ser_te_we), .ser_te_data(ser_te_data),
      .cnt_we(cnt_we), .cnt_data(cnt_data),
      .ext_brk_i(ext_brk_i), .brk_ack_i(brk_ack_i), .brk_req_o(brk_req_o)
   );

   // Advance one edge; inputs set by the caller before, sampling 1 ns after
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic [NUM_WP-1:0] m);
      wp_match_i = m;
      step();
      wp_match_i = '0;
   endtask

   task automatic sw_te(input logic [NUM_WP-1:0] v);
      sw_te_we = 1'b1; sw_te_data = v;
      step();
      sw_te_we = 1'b0;
   endtask

   task automatic load_cnt(input logic [NUM_WP-1:0] mask, input logic [CNT_W-1:0] v);
      cnt_we = mask; cnt_data = v;
      step();
      cnt_we = '0;
   endtask

   task automatic ack(input string req);
      brk_ack_i = 1'b1;
      step();
      brk_ack_i = 1'b0;
      chk(req, brk_req_o, 1'b0);
   endtask

   task automatic t_reset();
      chk("R2 brk after reset", brk_req_o, 1'b0);
      chk("R2 pins after reset", wp_pin_o, 4'b0000);
      pulse(4'b0001);
      chk("R2 trap enables clear", brk_req_o, 1'b0);
   endtask

   task automatic t_pins();
      pulse(4'b1010);
      chk("R1 pins follow match", wp_pin_o, 4'b1010);
      chk("R4 no trap enable no break", brk_req_o, 1'b0);
      step();
      chk("R1 pins return low", wp_pin_o, 4'b0000);
   endtask

   task automatic t_first();
      sw_te(4'b0001);
      pulse(4'b0001);
      chk("R3 count zero breaks first", brk_req_o, 1'b1);
      repeat (3) step();
      chk("R9 request held", brk_req_o, 1'b1);
      ack("R9 ack clears");
      load_cnt(4'b0010, 8'd1);
      sw_te(4'b0010);
      pulse(4'b0010);
      chk("R3 count one breaks first", brk_req_o, 1'b1);
      ack("R9 ack clears wp1");
   endtask

   task automatic t_count();
      load_cnt(4'b0100, 8'd3);
      sw_te(4'b0100);
      pulse(4'b0100);
      chk("R7 first of three", brk_req_o, 1'b0);
      pulse(4'b0100);
      chk("R7 second of three", brk_req_o, 1'b0);
      pulse(4'b0100);
      chk("R7 third of three", brk_req_o, 1'b1);
      ack("R9 ack after count");
      wp_match_i = 4'b0100;
      step(); step();
      chk("R8 reload two held cycles", brk_req_o, 1'b0);
      step();
      wp_match_i = '0;
      chk("R8 reload third held cycle", brk_req_o, 1'b1);
      ack("R9 ack after reload");
   endtask

   task automatic t_disabled();
      load_cnt(4'b1000, 8'd2);
      sw_te(4'b0000);
      repeat (3) pulse(4'b1000);
      chk("R4 disabled never breaks", brk_req_o, 1'b0);
      ser_te_we = 1'b1; ser_te_data = 4'b1000;
      step();
      ser_te_we = 1'b0;
      pulse(4'b1000);
      chk("R7 disabled matches not counted", brk_req_o, 1'b0);
      pulse(4'b1000);
      chk("R7 break on second enabled", brk_req_o, 1'b1);
      ack("R9 ack wp3");
   endtask

   task automatic t_ser_wins();
      load_cnt(4'b1111, 8'd1);
      sw_te_we = 1'b1; sw_te_data = 4'b1111;
      ser_te_we = 1'b1; ser_te_data = 4'b0001;
      step();
      sw_te_we = 1'b0; ser_te_we = 1'b0;
      pulse(4'b1110);
      chk("R5 serial wins software bits off", brk_req_o, 1'b0);
      pulse(4'b0001);
      chk("R5 serial value enabled bit", brk_req_o, 1'b1);
      ack("R9 ack after R5");
   endtask

   task automatic t_ext();
      ext_brk_i = 1'b1;
      step();
      ext_brk_i = 1'b0;
      chk("R6 external break", brk_req_o, 1'b1);
      pulse(4'b0001);
      chk("R9 merged while pending", brk_req_o, 1'b1);
      brk_ack_i = 1'b1; ext_brk_i = 1'b1;
      step();
      brk_ack_i = 1'b0; ext_brk_i = 1'b0;
      chk("R9 event wins over ack", brk_req_o, 1'b1);
      ack("R9 ack clears after merge");
   endtask

   task automatic t_write_wins();
      cnt_we = 4'b0001; cnt_data = 8'd2; wp_match_i = 4'b0001;
      step();
      cnt_we = '0; wp_match_i = '0;
      chk("R10 write cycle no break", brk_req_o, 1'b0);
      pulse(4'b0001);
      chk("R10 match in write cycle not counted", brk_req_o, 1'b0);
      pulse(4'b0001);
      chk("R10 break on second after write", brk_req_o, 1'b1);
      ack("R9 ack after R10");
   endtask

   task automatic t_indep();
      sw_te(4'b0110);
      load_cnt(4'b0010, 8'd2);
      load_cnt(4'b0100, 8'd3);
      pulse(4'b0110);
      chk("R11 first joint match", brk_req_o, 1'b0);
      pulse(4'b0110);
      chk("R11 wp1 breaks on second", brk_req_o, 1'b1);
      ack("R9 ack wp1 independent");
      pulse(4'b0110);
      chk("R11 wp2 breaks on third", brk_req_o, 1'b1);
      ack("R9 ack wp2 independent");
      pulse(4'b0110);
      chk("R11 wp1 own reload", brk_req_o, 1'b1);
      ack("R9 ack final");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      step();
      t_reset();
      t_pins();
      t_first();
      t_count();
      t_disabled();
      t_ser_wins();
      t_ext();
      t_write_wins();
      t_indep();
      finish_run();
   end

   initial begin
      #800000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end
endmodule